// File: doc/BRIEF.md
# Frame-Counter Interrupt and Wake Generator

This block sits beside a display waveform engine and counts its frame-start strobes. A down-counter is reloaded from a programmed value each time it wraps. Each wrap sets a sticky status flag. The flag drives an interrupt request while its mask bit is set, and it can also raise a wake-up line that stays high until software disarms it. The wrap period is either `reload + 1` frames or `reload * 8 + 1` frames, chosen by a prescale-bypass bit.

Software reaches the block through a small write/read register port with a 3-bit address. Mask bits and wake arming are changed only by writing ones to dedicated set and clear addresses, and the status flag is cleared by writing a one. A signed 6-bit fine-contrast value is written into a shadow register and copied to the output only when the next frame starts.

The low-power waveform mode input does not change the counting. In that mode frames last twice as long, so the strobes simply arrive half as often. The mode is visible on a read-back bit.

Top module: `frame_event_gen`

## Requirements
- R1: After synchronous reset, `irq_o` and `wake_o` are 0, `contrast_o` is 0, and the mask, status flag and wake-armed bits all read 0.
- R2: Address 0 holds the reload value in bits [RELOAD_W-1:0] and the bypass bit in bit DATA_W-1 (bit 15 by default). With bypass = 1, successive wraps are exactly reload+1 frame strobes apart. A reload of 0 wraps on every strobe.
- R3: With bypass = 0, successive wraps are exactly reload*8+1 frame strobes apart.
- R4: The counter is 0 after reset, so the first frame strobe wraps. A reload value written mid-count does not alter the current count and is used at the next wrap.
- R5: A wrap sets the status flag, which reads back at bit 0 of address 2. `irq_o` is 1 exactly while the flag and the mask are both set.
- R6: Writing bit 0 = 1 to address 1 sets the mask, and writing bit 0 = 1 to address 2 clears it. Writes of 0 to either address leave it unchanged. The mask reads back at bit 0 of address 1.
- R7: Writing bit 0 = 1 to address 3 clears the status flag. If a wrap happens in the same cycle, the flag stays set.
- R8: At address 4, writing bit 0 = 1 arms wake-up and writing bit 1 = 1 disarms it; disarm wins if both are written. `wake_o` rises on a wrap while wake-up is armed and the mask is set. It then stays high, unaffected by status clear or masking, until a disarm write. Address 4 reads back the armed state in bit 0, `wake_o` in bit 1 and the mode input in bit 2.
- R9: Bits [5:0] written to address 5 go to a shadow register that reads back at address 5. `contrast_o` takes the shadow value at the next frame strobe. A strobe in the same cycle as the write copies the previous shadow value.
- R10: The low-power mode input has no effect on wrap periods counted in frame strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| lowpwr_mode | input | 1 | Low-power waveform mode flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Registered read data, valid one cycle after `rd_addr` |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Latched wake-up request |
| contrast_o | output | CON_W | Active signed fine-contrast value |

## Verification
The hardest case to reach is a status-clear write landing in the very cycle the counter wraps. The bench first drains the counter to a known phase using strobe counts derived from the reload value. It then raises the strobe and the clear write on the same clock edge and checks that the flag and the interrupt survive. The mid-count reload change is handled the same way: one strobe is issued, the reload and bypass are rewritten, and the bench confirms that the wrap comes from the old count before the new period (reload*8+1 = 17 frames) takes over. The contrast copy is also driven in the same cycle as its write, so the bench can confirm that the previous shadow value is the one applied.

// File: rtl/fevg_pkg.sv
package fevg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL     = 3'd0,
    REG_MASK_SET = 3'd1,
    REG_MASK_CLR = 3'd2,
    REG_STAT_CLR = 3'd3,
    REG_WAKE     = 3'd4,
    REG_CONTRAST = 3'd5
  } fevg_addr_e;

  typedef struct packed {
    logic mask_set;
    logic mask_clr;
    logic stat_clr;
    logic wake_arm;
    logic wake_dis;
  } fevg_cmd_t;
endpackage

// File: rtl/fevg_counter.sv
module fevg_counter #(
  parameter int RELOAD_W = 5,
  localparam int CNT_W = RELOAD_W + 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_start,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                bypass,
  output logic                wrap
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    if (bypass) load_val = {3'b000, reload};
    else        load_val = {reload, 3'b000};
  end

  assign wrap = frame_start && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (wrap)        cnt_q <= load_val;
    else if (frame_start) cnt_q <= cnt_q - 1'b1;
  end

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(cnt_q));
endmodule

// File: rtl/fevg_events.sv
module fevg_events
  import fevg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wrap,
  input  fevg_cmd_t cmd,
  output logic      mask_q,
  output logic      flag_q,
  output logic      armed_q,
  output logic      irq_o,
  output logic      wake_o
);
  logic mask_nxt, flag_nxt, armed_nxt, wake_nxt;

  always_comb begin
    mask_nxt = mask_q;
    if (cmd.mask_set)      mask_nxt = 1'b1;
    else if (cmd.mask_clr) mask_nxt = 1'b0;

    flag_nxt = flag_q;
    if (wrap)              flag_nxt = 1'b1;
    else if (cmd.stat_clr) flag_nxt = 1'b0;

    armed_nxt = armed_q;
    if (cmd.wake_dis)      armed_nxt = 1'b0;
    else if (cmd.wake_arm) armed_nxt = 1'b1;

    wake_nxt = wake_o | (wrap & armed_q & mask_q);
    if (cmd.wake_dis)      wake_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      wake_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      mask_q  <= mask_nxt;
      flag_q  <= flag_nxt;
      armed_q <= armed_nxt;
      wake_o  <= wake_nxt;
      irq_o   <= flag_nxt & mask_nxt;
    end
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q);

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.stat_clr && !wrap) |=> !flag_q);

  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.mask_set |=> mask_q);

  // R8
  wake_drop_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.wake_dis |=> !wake_o);

  // R8
  wake_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_o) |-> $past(wrap));
endmodule

// File: rtl/fevg_regs.sv
module fevg_regs
  import fevg_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RELOAD_W = 5,
  parameter int CON_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_start,
  input  logic                lowpwr_mode,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                mask_q,
  input  logic                flag_q,
  input  logic                armed_q,
  input  logic                wake_q,
  output logic [DATA_W-1:0]   rd_data,
  output logic [RELOAD_W-1:0] reload_q,
  output logic                bypass_q,
  output fevg_cmd_t           cmd,
  output logic [CON_W-1:0]    contrast_o
);
  logic [CON_W-1:0]  shadow_q;
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    cmd = '0;
    if (wr_en) begin
      case (wr_addr)
        REG_MASK_SET: cmd.mask_set = wr_data[0];
        REG_MASK_CLR: cmd.mask_clr = wr_data[0];
        REG_STAT_CLR: cmd.stat_clr = wr_data[0];
        REG_WAKE: begin
          cmd.wake_arm = wr_data[0];
          cmd.wake_dis = wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q   <= '0;
      bypass_q   <= 1'b0;
      shadow_q   <= '0;
      contrast_o <= '0;
    end else begin
      if (wr_en && wr_addr == REG_CTRL) begin
        reload_q <= wr_data[RELOAD_W-1:0];
        bypass_q <= wr_data[DATA_W-1];
      end
      if (wr_en && wr_addr == REG_CONTRAST) shadow_q <= wr_data[CON_W-1:0];
      if (frame_start) contrast_o <= shadow_q;
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (rd_addr)
      REG_CTRL: begin
        rd_nxt[RELOAD_W-1:0] = reload_q;
        rd_nxt[DATA_W-1]     = bypass_q;
      end
      REG_MASK_SET: rd_nxt[0] = mask_q;
      REG_MASK_CLR: rd_nxt[0] = flag_q;
      REG_WAKE:     rd_nxt[2:0] = {lowpwr_mode, wake_q, armed_q};
      REG_CONTRAST: rd_nxt[CON_W-1:0] = shadow_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  // R9
  contrast_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(contrast_o));
endmodule

// File: rtl/frame_event_gen.sv
module frame_event_gen
  import fevg_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RELOAD_W = 5,
  parameter int CON_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              lowpwr_mode,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic              wake_o,
  output logic [CON_W-1:0]  contrast_o
);
  logic [RELOAD_W-1:0] reload_q;
  logic                bypass_q;
  logic                wrap;
  logic                mask_q, flag_q, armed_q;
  fevg_cmd_t           cmd;

  fevg_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .reload(reload_q), .bypass(bypass_q), .wrap(wrap)
  );

  fevg_regs #(.DATA_W(DATA_W), .RELOAD_W(RELOAD_W), .CON_W(CON_W)) u_regs (
    .clk(clk), .rst(rst), .frame_start(frame_start), .lowpwr_mode(lowpwr_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .mask_q(mask_q), .flag_q(flag_q), .armed_q(armed_q), .wake_q(wake_o),
    .rd_data(rd_data), .reload_q(reload_q), .bypass_q(bypass_q),
    .cmd(cmd), .contrast_o(contrast_o)
  );

  fevg_events u_evt (
    .clk(clk), .rst(rst), .wrap(wrap), .cmd(cmd),
    .mask_q(mask_q), .flag_q(flag_q), .armed_q(armed_q),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  // R5
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (flag_q && mask_q));
endmodule

// File: tb/test_frame_event_gen.sv
module test_frame_event_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        lowpwr_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq_o, wake_o;
  logic [5:0]  contrast_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  frame_event_gen i_frame_event_gen (
    .clk(clk), .rst(rst), .frame_start(frame_start), .lowpwr_mode(lowpwr_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o), .wake_o(wake_o), .contrast_o(contrast_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic strobe();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    if (lowpwr_mode) repeat (3) @(negedge clk);
  endtask

  task automatic clr_stat();
    wr(3'd3, 16'h0001);
  endtask

  // n strobes: irq must stay low for the first n-1 and rise on the n-th
  task automatic period(input int n, input string req);
    for (int i = 1; i <= n; i++) begin
      strobe();
      chk(req, irq_o, (i == n));
    end
    clr_stat();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq", irq_o, 0);
    chk("R1 wake", wake_o, 0);
    chk("R1 contrast", contrast_o, 0);
    rd(3'd1, d); chk("R1 mask", d, 0);
    rd(3'd2, d); chk("R1 flag", d, 0);
    rd(3'd4, d); chk("R1 armed", d, 0);
  endtask

  task automatic t_first_wrap();
    logic [15:0] d;
    wr(3'd0, 16'h8003);
    wr(3'd1, 16'h0001);
    strobe();
    chk("R4 first strobe wraps", irq_o, 1);
    rd(3'd2, d); chk("R5 flag read", d, 1);
    clr_stat();
    chk("R5 irq after clear", irq_o, 0);
  endtask

  task automatic t_bypass();
    period(4, "R2 reload3 bypass");
    period(4, "R2 reload3 bypass again");
  endtask

  task automatic t_midcount_and_x8();
    strobe();
    chk("R4 no early wrap", irq_o, 0);
    wr(3'd0, 16'h0002);
    period(3, "R4 old count drains");
    period(17, "R3 reload2 x8+1");
  endtask

  task automatic t_lowpwr();
    logic [15:0] d;
    lowpwr_mode = 1'b1;
    rd(3'd4, d); chk("R10 mode readback", d[2], 1);
    wr(3'd0, 16'h8001);
    period(17, "R10 lowpwr drains 17");
    period(2, "R10 lowpwr reload1");
    lowpwr_mode = 1'b0;
    wr(3'd0, 16'h8000);
    period(2, "R2 drain to reload0");
    period(1, "R2 reload0 every strobe");
    period(1, "R2 reload0 every strobe again");
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(3'd1, 16'h0000); rd(3'd1, d); chk("R6 set zero no effect", d, 1);
    wr(3'd2, 16'h0000); rd(3'd1, d); chk("R6 clr zero no effect", d, 1);
    wr(3'd2, 16'h0001); rd(3'd1, d); chk("R6 mask cleared", d, 0);
    strobe();
    rd(3'd2, d); chk("R5 flag while masked", d, 1);
    chk("R5 irq masked", irq_o, 0);
    wr(3'd1, 16'h0001);
    chk("R5 irq on unmask", irq_o, 1);
    clr_stat();
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    @(negedge clk); frame_start = 1'b1; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h0001;
    @(negedge clk); frame_start = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R7 set wins irq", irq_o, 1);
    rd(3'd2, d); chk("R7 set wins flag", d, 1);
    clr_stat();
    chk("R7 clear", irq_o, 0);
  endtask

  task automatic t_wake();
    logic [15:0] d;
    strobe(); chk("R8 unarmed no wake", wake_o, 0);
    clr_stat();
    wr(3'd4, 16'h0001);
    chk("R8 arm alone no wake", wake_o, 0);
    strobe(); chk("R8 wake on wrap", wake_o, 1);
    clr_stat(); chk("R8 held after status clear", wake_o, 1);
    wr(3'd2, 16'h0001); chk("R8 held after mask clear", wake_o, 1);
    wr(3'd4, 16'h0002); chk("R8 disarm drops", wake_o, 0);
    wr(3'd4, 16'h0001);
    strobe(); chk("R8 masked no wake", wake_o, 0);
    rd(3'd4, d); chk("R8 armed readback", d[1:0], 2'b01);
    wr(3'd4, 16'h0003);
    rd(3'd4, d); chk("R8 disarm wins", d[0], 0);
    clr_stat();
    wr(3'd1, 16'h0001);
  endtask

  task automatic t_contrast();
    logic [15:0] d;
    wr(3'd5, 16'h003B);
    chk("R9 not before frame", contrast_o, 0);
    rd(3'd5, d); chk("R9 shadow readback", d, 16'h003B);
    strobe(); chk("R9 applied -5", contrast_o, 6'h3B);
    @(negedge clk); frame_start = 1'b1; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 16'h0005;
    @(negedge clk); frame_start = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R9 same-cycle keeps old", contrast_o, 6'h3B);
    strobe(); chk("R9 next frame new", contrast_o, 6'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first_wrap();
    t_bypass();
    t_midcount_and_x8();
    t_lowpwr();
    t_mask();
    t_set_wins();
    t_wake();
    t_contrast();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule